// File: doc/BRIEF.md
# Dual-Polynomial Reflected CRC-32 Byte Engine

This block computes a 32-bit reflected cyclic redundancy check over a stream of bytes. It takes one byte per clock. A select input chooses one of two generator polynomials. One is the common Ethernet/ZIP generator, written in reversed bit order as 0xEDB88320. The other is the Castagnoli (iSCSI) generator, written in reversed bit order as 0x82F63B78.

A message begins with a start pulse, which carries a seed value. The engine inverts the seed to form its working register. The output is always the inverse of that register, so after every accepted byte it shows a finished CRC. For a fresh message the seed is zero. To continue across several chunks, the finished CRC of the previous chunk is passed back in as the seed.

Each accepted byte is XORed into the low eight bits of the working register. It is then put through eight right-shift steps. Each step XORs the polynomial whenever the bit shifted out was a one. All eight steps are unrolled into one combinational update.

Top module: `crc_byte_engine`

## Requirements
- R1: While reset is held and in the cycle after it is released, `crc_o` is 0x00000000 and `ready_o` is 0.
- R2: One cycle after `start_i` is sampled high, `crc_o` equals the `seed_i` value sampled with it and `ready_o` is 1.
- R3: With `poly_sel_i` = 0 at start, the engine uses the reversed polynomial 0xEDB88320. A zero seed followed by the ASCII bytes "123456789" gives 0xCBF43926. A seed of 0xFFFFFFFF followed by the single byte 0x01 gives 0x88F8CF69, which is the inverse of lookup entry 1 (0x77073096).
- R4: With `poly_sel_i` = 1 at start, the engine uses the reversed polynomial 0x82F63B78. A zero seed followed by "123456789" gives 0xE3069283. A seed of 0xFFFFFFFF followed by byte 0x01 gives 0x0D947CFC, the inverse of lookup entry 1 (0xF26B8303).
- R5: A byte is accepted on every clock where `data_vld_i` is high, `ready_o` is 1 and `start_i` is low. `crc_o` shows the CRC of all bytes accepted so far one cycle after each accepted byte. `crc_o` holds its value in cycles with no accepted byte.
- R6: `poly_sel_i` is sampled only when `start_i` is high. Changing it later in a message has no effect on the result.
- R7: A message split into chunks gives the same final CRC as the whole message, when each chunk after the first is seeded with the previous chunk's `crc_o`.
- R8: A start pulse abandons any message in progress. Bytes sent before that pulse do not affect the new result.
- R9: When `start_i` and `data_vld_i` are high in the same cycle, the start takes effect and that byte is discarded.
- R10: After reset and before the first start, bytes presented with `data_vld_i` are ignored, and `crc_o` stays 0x00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a message or chunk; loads the seed and samples the polynomial select |
| seed_i | input | 32 | Starting CRC value: zero for a new message, or the previous chunk's result |
| poly_sel_i | input | 1 | 0 selects reversed 0xEDB88320, 1 selects reversed 0x82F63B78 |
| data_i | input | 8 | Message byte |
| data_vld_i | input | 1 | `data_i` holds a byte to absorb |
| crc_o | output | 32 | Finished CRC of the bytes absorbed since the last start |
| ready_o | output | 1 | High once a start has been taken since reset |

## Verification
Two functions can land on the same clock edge: loading a seed and absorbing a byte. The bench drives `start_i` and `data_vld_i` high together, with a byte that would change the result. It then sends the standard nine-byte check message and expects the plain check value; any other value shows the colliding byte was absorbed. A second collision-like case restarts in the middle of a message, and it is judged the same way.

// File: rtl/crc_eng_pkg.sv
package crc_eng_pkg;
  localparam int CRC_W  = 32;
  localparam int BYTE_W = 8;

  // Generators in reversed (LSB-first) bit order
  localparam logic [CRC_W-1:0] POLY_ETH_REV  = 32'hEDB8_8320;
  localparam logic [CRC_W-1:0] POLY_CAST_REV = 32'h82F6_3B78;

  typedef enum logic {
    POLY_ETH  = 1'b0,
    POLY_CAST = 1'b1
  } poly_kind_e;
endpackage

// File: rtl/crc_byte_step.sv
// Unrolled reflected CRC update: absorbs DATA_W bits in one combinational pass.
module crc_byte_step #(
  parameter int CRC_W  = 32,
  parameter int DATA_W = 8
) (
  input  logic [CRC_W-1:0]  state_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CRC_W-1:0]  poly_i,
  output logic [CRC_W-1:0]  state_o
);
  localparam int PAD_W = CRC_W - DATA_W;

  logic [CRC_W-1:0] stage [DATA_W+1];

  assign stage[0] = state_i ^ {{PAD_W{1'b0}}, data_i};

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign stage[b+1] = stage[b][0] ? ((stage[b] >> 1) ^ poly_i)
                                    : (stage[b] >> 1);
  end

  assign state_o = stage[DATA_W];
endmodule

// File: rtl/crc_poly_latch.sv
// Holds the polynomial choice taken at start for the rest of the message.
module crc_poly_latch
  import crc_eng_pkg::*;
#(
  parameter int               CRC_W  = 32,
  parameter logic [CRC_W-1:0] POLY_A = 32'hEDB8_8320,
  parameter logic [CRC_W-1:0] POLY_B = 32'h82F6_3B78
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             sel_i,
  output logic [CRC_W-1:0] poly_o
);
  poly_kind_e kind_q;

  always_ff @(posedge clk) begin
    if (rst)          kind_q <= POLY_ETH;
    else if (start_i) kind_q <= poly_kind_e'(sel_i);
  end

  assign poly_o = (kind_q == POLY_CAST) ? POLY_B : POLY_A;

  // R6
  sel_held_chk: assert property (@(posedge clk) disable iff (rst)
    !start_i |=> $stable(kind_q));
endmodule

// File: rtl/crc_byte_engine.sv
module crc_byte_engine
  import crc_eng_pkg::*;
#(
  parameter int               W_CRC  = CRC_W,
  parameter int               W_DATA = BYTE_W,
  parameter logic [W_CRC-1:0] POLY_0 = POLY_ETH_REV,
  parameter logic [W_CRC-1:0] POLY_1 = POLY_CAST_REV
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [W_CRC-1:0]  seed_i,
  input  logic              poly_sel_i,
  input  logic [W_DATA-1:0] data_i,
  input  logic              data_vld_i,
  output logic [W_CRC-1:0]  crc_o,
  output logic              ready_o
);
  logic [W_CRC-1:0] work_q;
  logic [W_CRC-1:0] work_nxt;
  logic [W_CRC-1:0] poly;
  logic             armed_q;
  logic             take_byte;

  crc_poly_latch #(.CRC_W(W_CRC), .POLY_A(POLY_0), .POLY_B(POLY_1)) u_poly (
    .clk    (clk),
    .rst    (rst),
    .start_i(start_i),
    .sel_i  (poly_sel_i),
    .poly_o (poly)
  );

  crc_byte_step #(.CRC_W(W_CRC), .DATA_W(W_DATA)) u_step (
    .state_i(work_q),
    .data_i (data_i),
    .poly_i (poly),
    .state_o(work_nxt)
  );

  // Start has priority; a byte is absorbed only inside an armed message.
  assign take_byte = data_vld_i && armed_q && !start_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      work_q  <= '1;
      armed_q <= 1'b0;
    end else if (start_i) begin
      work_q  <= ~seed_i;
      armed_q <= 1'b1;
    end else if (take_byte) begin
      work_q  <= work_nxt;
    end
  end

  assign crc_o   = ~work_q;
  assign ready_o = armed_q;

  // R2 R9
  seed_load_chk: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (crc_o == $past(seed_i)) && ready_o);

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!start_i && !data_vld_i) |=> $stable(crc_o));

  // R10
  unarmed_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!ready_o && !start_i) |=> !ready_o && $stable(crc_o));

  // R1
  post_reset_chk: assert property (@(posedge clk)
    $past(rst) |-> (crc_o == '0) && !ready_o);
endmodule

// File: tb/crc_byte_engine_tb.sv
module crc_byte_engine_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [31:0] seed_i = '0;
  logic        poly_sel_i = 1'b0;
  logic [7:0]  data_i = '0;
  logic        data_vld_i = 1'b0;
  logic [31:0] crc_o;
  logic        ready_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;  // 125 MHz

  crc_byte_engine u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .seed_i(seed_i),
    .poly_sel_i(poly_sel_i), .data_i(data_i), .data_vld_i(data_vld_i),
    .crc_o(crc_o), .ready_o(ready_o)
  );

  // {sel, seed, byte count from "123456789", expected}
  localparam logic [68:0] VEC [4] = '{
    {1'b0, 32'h0000_0000, 4'd9, 32'hCBF4_3926},
    {1'b1, 32'h0000_0000, 4'd9, 32'hE306_9283},
    {1'b0, 32'h1234_5678, 4'd0, 32'h1234_5678},
    {1'b1, 32'hDEAD_BEEF, 4'd0, 32'hDEAD_BEEF}
  };

  function automatic logic [7:0] msg(input int i);
    return 8'h31 + 8'(i);
  endfunction

  // Bit-serial model of the requirement text
  function automatic logic [31:0] ref_crc(input logic [31:0] seed, input logic sel,
                                          input int first, input int cnt);
    logic [31:0] r;
    logic [31:0] p;
    p = sel ? 32'h82F6_3B78 : 32'hEDB8_8320;
    r = ~seed;
    for (int i = first; i < first + cnt; i++) begin
      r = r ^ {24'd0, msg(i)};
      for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ p) : (r >> 1);
    end
    return ~r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic do_start(input logic [31:0] seed, input logic sel);
    @(negedge clk);
    start_i = 1'b1; seed_i = seed; poly_sel_i = sel;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    data_i = b; data_vld_i = 1'b1;
    @(negedge clk);
    data_vld_i = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] part;
    repeat (3) @(negedge clk);
    check("R1 crc in reset", crc_o, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 crc after reset", crc_o, 32'h0);
    check("R1 ready after reset", {31'd0, ready_o}, 32'd0);

    // R10: bytes before any start are ignored
    send(8'hA5); send(8'h3C);
    check("R10 crc unarmed", crc_o, 32'h0);
    check("R10 ready unarmed", {31'd0, ready_o}, 32'd0);

    // Vector table: R2 seed load, R3/R4 check values
    for (int v = 0; v < 4; v++) begin
      do_start(VEC[v][67:36], VEC[v][68]);
      check("R2 ready after start", {31'd0, ready_o}, 32'd1);
      for (int i = 0; i < int'(VEC[v][35:32]); i++) send(msg(i));
      if (VEC[v][35:32] == 4'd0) check("R2 seed passthrough", crc_o, VEC[v][31:0]);
      else if (VEC[v][68])       check("R4 castagnoli check", crc_o, VEC[v][31:0]);
      else                       check("R3 ethernet check", crc_o, VEC[v][31:0]);
    end

    // R3 / R4 lookup entry 1
    do_start(32'hFFFF_FFFF, 1'b0); send(8'h01);
    check("R3 table entry 1", crc_o, 32'h88F8_CF69);
    do_start(32'hFFFF_FFFF, 1'b1); send(8'h01);
    check("R4 table entry 1", crc_o, 32'h0D94_7CFC);

    // R5: per-byte update with idle gaps
    do_start(32'h0, 1'b1);
    for (int i = 0; i < 9; i++) begin
      send(msg(i));
      check("R5 per byte", crc_o, ref_crc(32'h0, 1'b1, 0, i + 1));
      if (i == 4) begin
        @(negedge clk); @(negedge clk);
        check("R5 hold on idle", crc_o, ref_crc(32'h0, 1'b1, 0, 5));
      end
    end

    // R6: select changes mid-message are ignored
    do_start(32'h0, 1'b0);
    for (int i = 0; i < 9; i++) begin
      poly_sel_i = i[0];
      send(msg(i));
    end
    check("R6 select held", crc_o, 32'hCBF4_3926);

    // R7: chained chunks, both polynomials
    for (int s = 0; s < 2; s++) begin
      do_start(32'h0, s[0]);
      for (int i = 0; i < 4; i++) send(msg(i));
      part = crc_o;
      do_start(part, s[0]);
      for (int i = 4; i < 9; i++) send(msg(i));
      check("R7 chunked", crc_o, s[0] ? 32'hE306_9283 : 32'hCBF4_3926);
    end

    // R8: restart abandons message in progress
    do_start(32'h0, 1'b0);
    send(8'h41); send(8'h42);
    do_start(32'h0, 1'b0);
    for (int i = 0; i < 9; i++) send(msg(i));
    check("R8 restart discards", crc_o, 32'hCBF4_3926);

    // R9: start and byte in same cycle, byte dropped
    @(negedge clk);
    start_i = 1'b1; seed_i = 32'h0; poly_sel_i = 1'b0;
    data_i = 8'h77; data_vld_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; data_vld_i = 1'b0;
    check("R9 colliding byte dropped", crc_o, 32'h0);
    for (int i = 0; i < 9; i++) send(msg(i));
    check("R9 message after collision", crc_o, 32'hCBF4_3926);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule